// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block sits between a simple request/response port and a dynamic memory array of 2048 rows by 2048 columns of 4-bit cells, which is 4M locations of 4 bits. A requester presents a flat 22-bit location index together with a read or write flag. The controller splits the index into a row half and a column half and sends both over one shared 11-bit pin bus. The row goes first, marked by the row strobe. The column follows, marked by the column strobe. A precharge gap then lets the array recover.

An interval timer asks for a refresh every `REF_INTERVAL` clock cycles. A refresh opens one row with the row strobe only, which makes the array read that row and write it back, and then closes it again. A row counter moves through every row in turn. While a refresh is pending or running, the request port holds `req_ready` low, so any waiting request stalls until the array is free again.

Top module: `dram_ctrl`

## Requirements
- R1: During reset and right after it, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are high, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: An accepted request makes the row strobe fall on the next clock with `mem_addr` = index bits [ROW_W+COL_W-1:COL_W] (the row). When the column strobe falls, `mem_addr` = index bits [COL_W-1:0] (the column), zero-extended.
- R3: The column strobe falls exactly `T_RCD` cycles after the row strobe falls.
- R4: For a write, `mem_we_n` is low, `mem_dq_oe` is high and `mem_dq_out` equals the request data while the column strobe is low. For a read, `mem_we_n` stays high and `mem_dq_oe` stays low. A stored value reads back unchanged.
- R5: A read returns its data with `rsp_valid` high for exactly one cycle, `T_RCD + T_CAS` cycles after the clock edge that accepted it. Writes produce no response.
- R6: The row strobe stays low for `T_RCD + T_CAS` cycles (the access time). Both strobes are then high for at least `T_RP` cycles before the next row strobe. `req_ready` is low from the accepting edge until precharge ends, which is `T_RCD + T_CAS + T_RP` cycles when no refresh follows.
- R7: A refresh request arises every `REF_INTERVAL` cycles, counted from reset. A refresh holds the row strobe low for `T_RCD + T_CAS` cycles and never asserts the column strobe.
- R8: The row refreshed after reset is row 0. Each later refresh takes the next row, and the row after 2^ROW_W-1 is 0.
- R9: If a refresh and a request are both waiting in an idle cycle, the refresh starts first. Each refresh starts at most `T_RCD + T_CAS + T_RP + 1` cycles after its request arises, even under a continuous stream of requests.
- R10: While a refresh is in progress, `req_ready` is low and no request reaches the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W (22) | Flat location index: row in the upper part, column in the lower part |
| req_wdata | input | DATA_W (4) | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W (4) | Read data |
| mem_addr | output | max(ROW_W,COL_W) (11) | Shared row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W (4) | Data toward the array |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W (4) | Data from the array |

## Verification
Every result has a fixed delay from an event the bench can see at the pins. The row strobe falls one cycle after the accepting edge. The column strobe falls `T_RCD` cycles after that. Read data appears `T_RCD + T_CAS` cycles after acceptance. The row strobe rises `T_RCD + T_CAS` cycles after it fell. Refresh starts fall within a window measured from reset and from one another.

The bench samples all outputs on the falling clock edge and drives inputs just after the rising edge. It stamps each strobe edge and each acceptance with a cycle count and compares the differences with the sums of the timing parameters. The read-back check is exact. The check that `req_ready` is low for exactly the full cycle time is applied only when no refresh started inside that window.

// File: rtl/dram_pkg.sv
`timescale 1ns/1ps
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_REF,
    ST_PRE
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles the row strobe stays low: access time
  function automatic int access_cycles(input int rcd, input int cas);
    return rcd + cas;
  endfunction

  // full cycle time: access time plus recovery
  function automatic int cycle_cycles(input int rcd, input int cas, input int rp);
    return rcd + cas + rp;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
`timescale 1ns/1ps
module dram_ref_timer #(
  parameter int ROW_W        = 11,
  parameter int REF_INTERVAL = 3125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_grant,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TMR_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

  logic [TMR_W-1:0] tmr;
  logic             tmr_tick;

  assign tmr_tick = (tmr == TMR_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (tmr_tick) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pend <= 1'b0;
    end else if (tmr_tick) begin
      ref_pend <= 1'b1;
    end else if (ref_grant) begin
      ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_row <= '0;
    end else if (ref_grant) begin
      ref_row <= (ref_row == ROW_LAST) ? '0 : ref_row + 1'b1;
    end
  end

endmodule

// File: rtl/dram_seq.sv
`timescale 1ns/1ps
module dram_seq
  import dram_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  input  logic                                     req_we,
  input  logic [ROW_W-1:0]                         req_row,
  input  logic [COL_W-1:0]                         req_col,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     req_ready,
  input  logic                                     ref_pend,
  input  logic [ROW_W-1:0]                         ref_row,
  output logic                                     ref_grant,
  output logic                                     seq_idle,
  output logic                                     rsp_valid,
  output logic [DATA_W-1:0]                        rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] pin_addr,
  output logic                                     ras_n,
  output logic                                     cas_n,
  output logic                                     we_n,
  output logic [DATA_W-1:0]                        dq_out,
  output logic                                     dq_oe,
  input  logic [DATA_W-1:0]                        dq_in
);
  localparam int PIN_W = max2(ROW_W, COL_W);
  localparam int T_ACC = access_cycles(T_RCD, T_CAS);
  localparam int CNT_W = $clog2(cycle_cycles(T_RCD, T_CAS, T_RP) + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_zero;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  assign seq_idle  = (state == ST_IDLE);
  assign req_ready = seq_idle && !ref_pend;
  assign ref_grant = seq_idle && ref_pend;
  assign cnt_zero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      col_q     <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      pin_addr  <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            state    <= ST_REF;
            pin_addr <= PIN_W'(ref_row);
            ras_n    <= 1'b0;
            cnt      <= CNT_W'(T_ACC - 1);
          end else if (req_valid) begin
            state    <= ST_ROW;
            pin_addr <= PIN_W'(req_row);
            ras_n    <= 1'b0;
            cnt      <= CNT_W'(T_RCD - 1);
            col_q    <= req_col;
            we_q     <= req_we;
            wdata_q  <= req_wdata;
          end
        end
        ST_ROW: begin
          if (cnt_zero) begin
            state    <= ST_COL;
            pin_addr <= PIN_W'(col_q);
            cas_n    <= 1'b0;
            we_n     <= !we_q;
            dq_oe    <= we_q;
            dq_out   <= wdata_q;
            cnt      <= CNT_W'(T_CAS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_COL: begin
          if (cnt_zero) begin
            state <= ST_PRE;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            cnt   <= CNT_W'(T_RP - 1);
            if (!we_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dq_in;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REF: begin
          if (cnt_zero) begin
            state <= ST_PRE;
            ras_n <= 1'b1;
            cnt   <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt_zero) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_ctrl.sv
`timescale 1ns/1ps
module dram_ctrl #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 4,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 3125
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic                                     req_we,
  input  logic [ROW_W+COL_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     rsp_valid,
  output logic [DATA_W-1:0]                        rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic                                     mem_ras_n,
  output logic                                     mem_cas_n,
  output logic                                     mem_we_n,
  output logic [DATA_W-1:0]                        mem_dq_out,
  output logic                                     mem_dq_oe,
  input  logic [DATA_W-1:0]                        mem_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             ref_pend;
  logic             ref_grant;
  logic             seq_idle;
  logic [ROW_W-1:0] ref_row;

  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  dram_ref_timer #(
    .ROW_W       (ROW_W),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_grant(ref_grant),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  dram_seq #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_we   (req_we),
    .req_row  (req_row),
    .req_col  (req_col),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .ref_pend (ref_pend),
    .ref_row  (ref_row),
    .ref_grant(ref_grant),
    .seq_idle (seq_idle),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .pin_addr (mem_addr),
    .ras_n    (mem_ras_n),
    .cas_n    (mem_cas_n),
    .we_n     (mem_we_n),
    .dq_out   (mem_dq_out),
    .dq_oe    (mem_dq_oe),
    .dq_in    (mem_dq_in)
  );

endmodule

// File: rtl/dram_ctrl_chk.sv
`timescale 1ns/1ps
module dram_ctrl_chk #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int T_RCD = 2
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     req_ready,
  input logic                                     rsp_valid,
  input logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  input logic                                     mem_ras_n,
  input logic                                     mem_cas_n,
  input logic                                     mem_we_n,
  input logic                                     mem_dq_oe,
  input logic                                     ref_pend,
  input logic                                     ref_grant,
  input logic                                     seq_idle,
  input logic [ROW_W-1:0]                         ref_row
);
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

  logic [15:0] ras_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_cnt <= '0;
    end else if (mem_ras_n) begin
      ras_cnt <= '0;
    end else if (ras_cnt != 16'hFFFF) begin
      ras_cnt <= ras_cnt + 1'b1;
    end
  end

  p_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> ras_cnt == 16'(T_RCD));

  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ras_n |-> !req_ready);

  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |-> (!req_ready && mem_cas_n));

  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cas_n && mem_dq_oe));

  p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && ref_pend) |=> (!mem_ras_n && mem_cas_n && mem_addr == PIN_W'($past(ref_row))));

  p_row_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |=> ref_row == (($past(ref_row) == ROW_LAST) ? '0 : $past(ref_row) + 1'b1));

endmodule

bind dram_ctrl dram_ctrl_chk #(
  .ROW_W(ROW_W),
  .COL_W(COL_W),
  .T_RCD(T_RCD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n),
  .mem_we_n (mem_we_n),
  .mem_dq_oe(mem_dq_oe),
  .ref_pend (ref_pend),
  .ref_grant(ref_grant),
  .seq_idle (seq_idle),
  .ref_row  (ref_row)
);

// File: tb/dram_ctrl_tb.sv
`timescale 1ns/1ps
module dram_ctrl_tb;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 3;
  localparam int DATA_W = 4;
  localparam int T_RCD  = 3;
  localparam int T_CAS  = 2;
  localparam int T_RP   = 2;
  localparam int RI     = 20;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int LOCS   = 1 << ADDR_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int TACC   = T_RCD + T_CAS;
  localparam int TC     = T_RCD + T_CAS + T_RP;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [PIN_W-1:0]  mem_addr;
  logic              mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [DATA_W-1:0] mem_dq_out;
  logic [DATA_W-1:0] mem_dq_in = '0;

  dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(RI)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a, input int k);
    return DATA_W'(a * 5 + k * 3 + 1);
  endfunction

  // behavioural array and bench expectations
  logic [DATA_W-1:0] arr [LOCS];
  logic [DATA_W-1:0] exp_mem [LOCS];
  int                due_q [$];
  logic [DATA_W-1:0] dat_q [$];

  int rel_cyc = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, prev_rsp = 1'b0;
  bit in_op = 1'b0, op_is_acc = 1'b0, op_cas_seen = 1'b0;
  int ras_fall_cyc = 0, ras_rise_cyc = -1, last_ref = -1;
  int ref_cnt = 0, wraps = 0, exp_ref_row = 0, n_rsp = 0;
  logic [ROW_W-1:0] cur_row = '0;
  bit acc_due = 1'b0, acc_we = 1'b0;
  int acc_cyc = 0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [DATA_W-1:0] acc_wdata = '0;
  bit rdy_track = 1'b0, ref_in_win = 1'b0;
  int rdy_low = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      // read responses
      if (rsp_valid) begin
        chk(!prev_rsp, "R5 single-cycle pulse", 1, 0);
        n_rsp++;
        if (due_q.size() == 0) begin
          chk(1'b0, "R5 unexpected response", 1, 0);
        end else begin
          chk(cyc == due_q[0], "R5 read latency", cyc, due_q[0]);
          chk(rsp_rdata == dat_q[0], "R5/R4 read data", rsp_rdata, dat_q[0]);
          void'(due_q.pop_front());
          void'(dat_q.pop_front());
        end
      end
      prev_rsp = rsp_valid;

      if (in_op && !op_is_acc)
        chk(!req_ready, "R10 port stalled during refresh", req_ready, 0);

      // row strobe falling
      if (!mem_ras_n && prev_ras) begin
        if (ras_rise_cyc >= 0)
          chk(cyc - ras_rise_cyc >= T_RP + 1, "R6 precharge gap", cyc - ras_rise_cyc, T_RP + 1);
        in_op = 1'b1;
        ras_fall_cyc = cyc;
        op_cas_seen = 1'b0;
        if (acc_due) begin
          op_is_acc = 1'b1;
          acc_due = 1'b0;
          chk(cyc == acc_cyc + 1, "R2 row strobe one cycle after accept", cyc, acc_cyc + 1);
          chk(int'(mem_addr) == int'(acc_addr >> COL_W), "R2 row address", mem_addr, int'(acc_addr >> COL_W));
          cur_row = ROW_W'(mem_addr);
        end else begin
          op_is_acc = 1'b0;
          chk(int'(mem_addr) == exp_ref_row, "R8 refresh row", mem_addr, exp_ref_row);
          if (exp_ref_row == ROWS - 1) wraps++;
          exp_ref_row = (exp_ref_row + 1) % ROWS;
          if (last_ref < 0)
            chk(cyc - rel_cyc >= RI + 1 && cyc - rel_cyc <= RI + 1 + TC,
                "R7 first refresh time", cyc - rel_cyc, RI + 1);
          else
            chk(cyc - last_ref >= RI - TC && cyc - last_ref <= RI + TC,
                "R9 refresh spacing", cyc - last_ref, RI);
          last_ref = cyc;
          ref_cnt++;
          if (rdy_track) ref_in_win = 1'b1;
        end
      end

      // column strobe falling
      if (!mem_cas_n && prev_cas) begin
        op_cas_seen = 1'b1;
        if (!in_op || !op_is_acc) begin
          chk(1'b0, "R10 column strobe during refresh", 1, 0);
        end else begin
          chk(cyc - ras_fall_cyc == T_RCD, "R3 row-to-column delay", cyc - ras_fall_cyc, T_RCD);
          chk(int'(mem_addr) == int'(acc_addr[COL_W-1:0]), "R2 column address", mem_addr, acc_addr[COL_W-1:0]);
          if (acc_we) begin
            chk(!mem_we_n && mem_dq_oe, "R4 write strobes", {mem_we_n, mem_dq_oe}, 1);
            chk(mem_dq_out == acc_wdata, "R4 write data", mem_dq_out, acc_wdata);
          end else begin
            chk(mem_we_n && !mem_dq_oe, "R4 read strobes", {mem_we_n, mem_dq_oe}, 2);
          end
        end
        if (!mem_we_n) arr[{cur_row, mem_addr[COL_W-1:0]}] = mem_dq_out;
        else mem_dq_in = arr[{cur_row, mem_addr[COL_W-1:0]}];
      end

      // row strobe rising
      if (mem_ras_n && !prev_ras) begin
        if (op_is_acc)
          chk(cyc - ras_fall_cyc == TACC, "R6 access row-strobe length", cyc - ras_fall_cyc, TACC);
        else
          chk(cyc - ras_fall_cyc == TACC && !op_cas_seen, "R7 refresh row-strobe length",
              cyc - ras_fall_cyc, TACC);
        in_op = 1'b0;
        ras_rise_cyc = cyc;
      end

      // ready window after an accept
      if (rdy_track) begin
        if (!req_ready) begin
          rdy_low++;
        end else begin
          chk(rdy_low >= TC, "R6 ready low through precharge", rdy_low, TC);
          if (!ref_in_win) chk(rdy_low == TC, "R6 ready low exact", rdy_low, TC);
          rdy_track = 1'b0;
        end
      end

      // acceptance happens on the coming rising edge
      if (req_valid && req_ready) begin
        acc_due = 1'b1;
        acc_cyc = cyc;
        acc_addr = req_addr;
        acc_we = req_we;
        acc_wdata = req_wdata;
        rdy_track = 1'b1;
        rdy_low = 0;
        ref_in_win = 1'b0;
        if (req_we) begin
          exp_mem[req_addr] = req_wdata;
        end else begin
          due_q.push_back(cyc + 1 + TACC);
          dat_q.push_back(exp_mem[req_addr]);
        end
      end

      prev_ras = mem_ras_n;
      prev_cas = mem_cas_n;
    end
  end

  task automatic do_op(input bit we, input int a, input logic [DATA_W-1:0] d);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = ADDR_W'(a);
    req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < LOCS; i++) begin
      arr[i] = '0;
      exp_mem[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_ras_n && mem_cas_n && mem_we_n, "R1 strobes idle in reset", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !rsp_valid, "R1 outputs quiet in reset", {mem_dq_oe, rsp_valid}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    rel_cyc = cyc;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(mem_ras_n && mem_cas_n, "R1 strobes high after reset", {mem_ras_n, mem_cas_n}, 3);
    @(posedge clk);
    #1;

    // sweep: write all, read all, then write/read pairs in reverse
    for (int a = 0; a < LOCS; a++) do_op(1'b1, a, pat(a, 0));
    for (int a = 0; a < LOCS; a++) do_op(1'b0, a, '0);
    for (int a = LOCS - 1; a >= 0; a--) begin
      do_op(1'b1, a, pat(a, 1));
      do_op(1'b0, a, '0);
    end
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(n_rsp == 2 * LOCS, "R5 response count", n_rsp, 2 * LOCS);
    chk(due_q.size() == 0, "R5 no missing responses", due_q.size(), 0);
    chk(wraps >= 2, "R8 row counter wrapped", wraps, 2);
    chk(ref_cnt >= (cyc - rel_cyc) / RI - 1 && ref_cnt <= (cyc - rel_cyc) / RI,
        "R7 refresh count", ref_cnt, (cyc - rel_cyc) / RI);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

endmodule